// File: doc/BRIEF.md
# Line-Interface Serial Status Port

This block is the host-facing serial port of a line interface. A host selects it with an active-low chip select and clocks in a command byte. Bit 0 of that byte selects read (1) or write (0), bits 6:1 carry a device address, and bit 7 is ignored. After a write command the host clocks in one control byte. After a read command the block shifts out one status byte on the next eight serial clocks. Every byte travels least-significant bit first. Serial inputs are sampled on the rising edge of the serial clock. Read data changes on the falling edge, so the host samples it on the next rising edge. All serial pins and the two monitor inputs pass through synchronizers into the system clock domain.

The status byte has these fields. D0 is the live loss-of-signal flag. D1 is the live driver-monitor flag. D4:D2 read back the programmed line-length code. D7:D5 hold a three-bit code. That code reports either a latched change of a monitor input or the active test/loopback mode. The block watches both monitor inputs for any change. When a change occurs on an enabled source, the block latches it and pulls the interrupt line low. The host acknowledges each source through its clear bit in the control byte. A clear bit of 1 also masks that source. Reading the status byte has no effect on the interrupt state.

Top module: `lif_status_port`

## Requirements
- R1: A write is a command byte with bit 0 = 0 and bits 6:1 = DEV_ADDR, followed by one control byte. The control byte layout is: bit 0 clears the loss-of-signal source, bit 1 clears the driver-monitor source, bits 4:2 are the line-length code, bit 5 is all-ones transmit, bit 6 is local loopback and bit 7 is remote loopback. The control outputs change only after the eighth data bit. A write aborted earlier leaves them unchanged.
- R2: After a read command (bit 0 = 1, matching address), the status byte is shifted out LSB first. Each bit becomes valid after a falling edge, for the eight rising edges that follow the command byte. The byte is captured at the end of the command byte.
- R3: `sdo_oe` is high only while read data is being presented. It falls after the falling edge that follows the sixteenth rising edge, and whenever chip select is deasserted.
- R4: In the status byte, D0 is the synchronized loss-of-signal input, D1 is the synchronized driver-monitor input and D4:D2 is the programmed line-length code.
- R5: With no change pending, the code {D5,D6,D7} reads 000 when no mode is set. It reads 001 for all-ones transmit, 010 for local loopback and 011 for both. It reads 100 whenever remote loopback is set.
- R6: Any edge of an enabled monitor input latches a change and drives `int_n` low. The code {D5,D6,D7} then reads 101 for a driver-monitor change, 110 for a loss-of-signal change and 111 for both.
- R7: A clear bit of 1 removes that source's pending change and masks it, so later edges on that source neither latch nor interrupt.
- R8: A clear bit of 0 enables its source without creating a pending change.
- R9: Reading the status byte leaves every pending change and `int_n` unchanged.
- R10: A pending change code overrides any mode code.
- R11: A command whose address bits differ from DEV_ADDR is ignored. It neither drives `sdo_oe` nor alters the control outputs.
- R12: After reset, both sources are masked, nothing is pending, `int_n` is high, every control output is 0 and the status byte reads 0 with both monitor inputs low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Host serial clock |
| cs_n | input | 1 | Active-low chip select |
| sdi | input | 1 | Serial data from host |
| sdo | output | 1 | Serial read data |
| sdo_oe | output | 1 | Output enable for `sdo`; the pad floats when low |
| los_in | input | 1 | Loss-of-signal flag |
| dpm_in | input | 1 | Driver-monitor flag |
| int_n | output | 1 | Active-low interrupt, low while any change is pending |
| len_sel | output | 3 | Programmed line-length code |
| tx_all_ones | output | 1 | All-ones transmit request |
| local_loop | output | 1 | Local loopback request |
| remote_loop | output | 1 | Remote loopback request |

## Verification
The embedded assertions check several properties on every cycle:
- a pending change never coexists with its mask;
- a clear always empties its source;
- without a write, a pending change persists, including through reads;
- the output enable tracks the read phase and drops on deselect;
- the captured read byte stays frozen between falling edges;
- a control update happens only at the sixteenth serial bit;
- a pending change always shows a change code.

Only the bench scenarios can show the following: the exact bit order on the wire, the encoding of each mode and change code, that masked edges are truly lost, and that aborted or misaddressed transfers leave the controls unchanged.

// File: rtl/lif_pkg.sv
package lif_pkg;

    localparam int BYTE_W = 8;
    localparam int NSRC   = 2;   // source 0: loss of signal, source 1: driver monitor

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_READ,
        PH_WRITE,
        PH_SKIP
    } phase_t;

    // control byte, bit 0 first on the wire
    typedef struct packed {
        logic       rloop;
        logic       lloop;
        logic       taos;
        logic [2:0] len;
        logic       clr_dpm;
        logic       clr_los;
    } ctrl_t;

    // status byte, code = {D7,D6,D5}
    typedef struct packed {
        logic [2:0] code;
        logic [2:0] len;
        logic       dpm;
        logic       los;
    } stat_t;

    function automatic logic [2:0] status_code(
        input logic pend_los,
        input logic pend_dpm,
        input logic taos,
        input logic lloop,
        input logic rloop
    );
        logic [2:0] c;
        if (pend_los || pend_dpm)
            c = {pend_dpm, pend_los, 1'b1};
        else if (rloop)
            c = 3'b001;
        else
            c = {taos, lloop, 1'b0};
        return c;
    endfunction

endpackage

// File: rtl/lif_sync.sv
module lif_sync #(
    parameter int              W       = 1,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] st [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) st[i] <= RST_VAL;
        end else begin
            st[0] <= d;
            for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
        end
    end

    assign q = st[STAGES-1];
endmodule

// File: rtl/lif_change_latch.sv
module lif_change_latch (
    input  logic clk,
    input  logic rst,
    input  logic mon,
    input  logic wr_valid,
    input  logic clr_req,
    output logic pending,
    output logic masked
);
    logic mon_q;
    logic edge_seen;

    assign edge_seen = mon ^ mon_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mon_q   <= 1'b0;
            pending <= 1'b0;
            masked  <= 1'b1;
        end else begin
            mon_q <= mon;
            if (wr_valid) begin
                masked <= clr_req;
                if (clr_req) pending <= 1'b0;
                else if (!masked && edge_seen) pending <= 1'b1;
            end else if (!masked && edge_seen) begin
                pending <= 1'b1;
            end
        end
    end

    // R7
    clear_empties_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && clr_req) |=> !pending);

    // R9
    hold_pending_chk: assert property (@(posedge clk) disable iff (rst)
        (pending && !wr_valid) |=> pending);

    // R7
    mask_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(pending && masked));
endmodule

// File: rtl/lif_serial_engine.sv
module lif_serial_engine
    import lif_pkg::*;
#(
    parameter int          ADDR_W   = 6,
    parameter logic [ADDR_W-1:0] DEV_ADDR = 6'h10
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  sclk_s,
    input  logic  desel_s,
    input  logic  sdi_s,
    input  stat_t status_in,
    output logic  wr_valid,
    output ctrl_t wr_data,
    output logic  sdo,
    output logic  sdo_oe
);
    localparam int TOTAL = 2 * BYTE_W;
    localparam int CNT_W = $clog2(TOTAL + 1);
    localparam logic [CNT_W-1:0] CMD_LAST  = CNT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(TOTAL - 1);
    localparam logic [CNT_W-1:0] CNT_DONE  = CNT_W'(TOTAL);

    logic              sclk_q;
    logic              rise, fall;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-2:0] shreg;
    logic [BYTE_W-1:0] next_byte;
    logic [BYTE_W-1:0] out_sh;
    logic              started;
    phase_t            phase;

    assign rise      = sclk_s & ~sclk_q;
    assign fall      = ~sclk_s & sclk_q;
    assign next_byte = {sdi_s, shreg};
    assign sdo       = sdo_oe & out_sh[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q <= 1'b0;
            shreg  <= '0;
            out_sh <= '0;
        end else begin
            sclk_q <= sclk_s;
            if (!desel_s && rise && cnt != CNT_DONE)
                shreg <= next_byte[BYTE_W-1:1];
            if (!desel_s && rise && cnt == CMD_LAST
                && next_byte[ADDR_W:1] == DEV_ADDR && next_byte[0])
                out_sh <= status_in;
            else if (!desel_s && fall && phase == PH_READ && started && cnt != CNT_DONE)
                out_sh <= out_sh >> 1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || desel_s) begin
            cnt      <= '0;
            phase    <= PH_IDLE;
            sdo_oe   <= 1'b0;
            started  <= 1'b0;
            wr_valid <= 1'b0;
            wr_data  <= '0;
        end else begin
            wr_valid <= 1'b0;
            if (rise && cnt != CNT_DONE) begin
                cnt <= cnt + 1'b1;
                if (cnt == CMD_LAST) begin
                    if (next_byte[ADDR_W:1] != DEV_ADDR) phase <= PH_SKIP;
                    else if (next_byte[0])               phase <= PH_READ;
                    else                                 phase <= PH_WRITE;
                end
                if (cnt == DATA_LAST && phase == PH_WRITE) begin
                    wr_valid <= 1'b1;
                    wr_data  <= ctrl_t'(next_byte);
                end
            end
            if (fall && phase == PH_READ) begin
                if (cnt == CNT_DONE) begin
                    sdo_oe <= 1'b0;
                    phase  <= PH_SKIP;
                end else if (!started) begin
                    sdo_oe  <= 1'b1;
                    started <= 1'b1;
                end
            end
        end
    end

    // R3
    deselect_float_chk: assert property (@(posedge clk) disable iff (rst)
        desel_s |=> !sdo_oe);

    // R3
    drive_in_read_chk: assert property (@(posedge clk) disable iff (rst)
        sdo_oe |-> phase == PH_READ);

    // R2
    frozen_byte_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_READ && !fall && !desel_s) |=> $stable(out_sh));

    // R1
    write_at_end_chk: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> cnt == CNT_DONE);
endmodule

// File: rtl/lif_status_port.sv
module lif_status_port
    import lif_pkg::*;
#(
    parameter int          SYNC_STAGES = 2,
    parameter int          ADDR_W      = 6,
    parameter logic [ADDR_W-1:0] DEV_ADDR = 6'h10
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sclk,
    input  logic       cs_n,
    input  logic       sdi,
    output logic       sdo,
    output logic       sdo_oe,
    input  logic       los_in,
    input  logic       dpm_in,
    output logic       int_n,
    output logic [2:0] len_sel,
    output logic       tx_all_ones,
    output logic       local_loop,
    output logic       remote_loop
);
    localparam int SYNC_W = 5;

    logic [SYNC_W-1:0] raw_in, syn;
    logic sclk_s, desel_s, sdi_s, los_s, dpm_s;

    assign raw_in = {sclk, cs_n, sdi, los_in, dpm_in};
    assign {sclk_s, desel_s, sdi_s, los_s, dpm_s} = syn;

    lif_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES), .RST_VAL(5'b01000)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_in),
        .q   (syn)
    );

    logic  wr_valid;
    ctrl_t wr_data;
    stat_t status;

    lif_serial_engine #(.ADDR_W(ADDR_W), .DEV_ADDR(DEV_ADDR)) u_engine (
        .clk       (clk),
        .rst       (rst),
        .sclk_s    (sclk_s),
        .desel_s   (desel_s),
        .sdi_s     (sdi_s),
        .status_in (status),
        .wr_valid  (wr_valid),
        .wr_data   (wr_data),
        .sdo       (sdo),
        .sdo_oe    (sdo_oe)
    );

    logic [NSRC-1:0] mon, clr, pend, mask;
    assign mon = {dpm_s, los_s};
    assign clr = {wr_data.clr_dpm, wr_data.clr_los};

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        lif_change_latch u_latch (
            .clk      (clk),
            .rst      (rst),
            .mon      (mon[g]),
            .wr_valid (wr_valid),
            .clr_req  (clr[g]),
            .pending  (pend[g]),
            .masked   (mask[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            len_sel     <= '0;
            tx_all_ones <= 1'b0;
            local_loop  <= 1'b0;
            remote_loop <= 1'b0;
        end else if (wr_valid) begin
            len_sel     <= wr_data.len;
            tx_all_ones <= wr_data.taos;
            local_loop  <= wr_data.lloop;
            remote_loop <= wr_data.rloop;
        end
    end

    always_comb begin
        status.los  = los_s;
        status.dpm  = dpm_s;
        status.len  = len_sel;
        status.code = status_code(pend[0], pend[1], tx_all_ones, local_loop, remote_loop);
    end

    assign int_n = ~|pend;

    // R10
    change_first_chk: assert property (@(posedge clk) disable iff (rst)
        (|pend) |-> status.code[0]);

    // R6
    irq_follows_chk: assert property (@(posedge clk) disable iff (rst)
        (!int_n) |-> (|pend) && !(&mask));
endmodule

// File: tb/lif_status_port_test.sv
`timescale 1ns/1ps
module lif_status_port_test;
    localparam int HALF = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sclk = 1'b0, cs_n = 1'b1, sdi = 1'b0;
    logic los_in = 1'b0, dpm_in = 1'b0;
    logic sdo, sdo_oe, int_n, tx_all_ones, local_loop, remote_loop;
    logic [2:0] len_sel;

    int checks = 0, errors = 0;
    bit done = 0;

    // bench model
    logic [2:0] m_len = 0;
    logic m_taos = 0, m_lloop = 0, m_rloop = 0;
    logic m_mask_los = 1, m_mask_dpm = 1, m_pl = 0, m_pd = 0;

    always #2.5 clk = ~clk;

    lif_status_port uut (
        .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .sdi(sdi),
        .sdo(sdo), .sdo_oe(sdo_oe), .los_in(los_in), .dpm_in(dpm_in),
        .int_n(int_n), .len_sel(len_sel), .tx_all_ones(tx_all_ones),
        .local_loop(local_loop), .remote_loop(remote_loop)
    );

    task automatic wait_clk(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    function automatic logic [7:0] exp_status();
        logic [2:0] c;
        if (m_pl || m_pd) c = {m_pd, m_pl, 1'b1};
        else if (m_rloop) c = 3'b001;
        else c = {m_taos, m_lloop, 1'b0};
        return {c, m_len, dpm_in, los_in};
    endfunction

    function automatic logic [7:0] mk(input logic cl, input logic cd, input logic [2:0] len,
                                      input logic ta, input logic ll, input logic rl);
        return {rl, ll, ta, len, cd, cl};
    endfunction

    task automatic serial(input logic [7:0] cmd, input logic [7:0] wdat, input int nbits,
                          input bit is_read, output logic [7:0] rd, output int oe_err);
        oe_err = 0;
        rd = '0;
        cs_n = 1'b0;
        wait_clk(HALF);
        for (int i = 0; i < nbits; i++) begin
            sclk = 1'b0;
            sdi = (i < 8) ? cmd[i] : wdat[i-8];
            wait_clk(HALF);
            if (i >= 8) rd[i-8] = sdo;
            if (sdo_oe !== (is_read && i >= 8)) oe_err++;
            sclk = 1'b1;
            wait_clk(HALF);
        end
        sclk = 1'b0;
        wait_clk(HALF);
        if (nbits == 16 && sdo_oe !== 1'b0) oe_err++;
        cs_n = 1'b1;
        wait_clk(HALF);
    endtask

    task automatic do_write(input logic [7:0] b);
        logic [7:0] rd;
        int oe_err;
        serial(8'h20, b, 16, 1'b0, rd, oe_err);
        m_len = b[4:2]; m_taos = b[5]; m_lloop = b[6]; m_rloop = b[7];
        m_mask_los = b[0]; if (b[0]) m_pl = 0;
        m_mask_dpm = b[1]; if (b[1]) m_pd = 0;
        chk("R3 no drive on write", oe_err, 0);
        chk("R1 controls", {len_sel, tx_all_ones, local_loop, remote_loop},
            {m_len, m_taos, m_lloop, m_rloop});
    endtask

    task automatic do_read(input string req);
        logic [7:0] rd;
        int oe_err;
        serial(8'h21, 8'h00, 16, 1'b1, rd, oe_err);
        chk(req, rd, exp_status());
        chk("R3 drive window", oe_err, 0);
    endtask

    task automatic set_mon(input logic l, input logic d);
        if (l != los_in && !m_mask_los) m_pl = 1;
        if (d != dpm_in && !m_mask_dpm) m_pd = 1;
        los_in = l; dpm_in = d;
        wait_clk(12);
    endtask

    task automatic t_reset();
        chk("R12 int_n", int_n, 1);
        chk("R12 controls", {len_sel, tx_all_ones, local_loop, remote_loop}, 0);
        chk("R12 sdo_oe", sdo_oe, 0);
        do_read("R12 status after reset");
    endtask

    task automatic t_controls();
        do_write(mk(1, 1, 3'd5, 0, 0, 0));
        do_read("R4 length readback");
        do_write(mk(1, 1, 3'd2, 0, 0, 0));
        do_read("R4 length readback 2");
    endtask

    task automatic t_modes();
        do_write(mk(1, 1, 3'd1, 1, 0, 0)); do_read("R5 all-ones code");
        do_write(mk(1, 1, 3'd1, 0, 1, 0)); do_read("R5 local loop code");
        do_write(mk(1, 1, 3'd1, 1, 1, 0)); do_read("R5 both code");
        do_write(mk(1, 1, 3'd1, 0, 0, 1)); do_read("R5 remote loop code");
        do_write(mk(1, 1, 3'd1, 1, 1, 1)); do_read("R5 remote overrides");
        do_write(mk(1, 1, 3'd0, 0, 0, 0)); do_read("R5 no mode code");
    endtask

    task automatic t_live_masked();
        set_mon(1, 0);
        chk("R7 masked edge no irq", int_n, 1);
        do_read("R4 live los flag");
        set_mon(1, 1);
        do_read("R4 live dpm flag");
        set_mon(0, 0);
        chk("R7 masked no irq", int_n, 1);
    endtask

    task automatic t_events();
        do_write(mk(0, 0, 3'd3, 0, 1, 0));
        chk("R8 enable no pending", int_n, 1);
        do_read("R8 enable leaves mode code");
        set_mon(1, 0);
        chk("R6 los irq", int_n, 0);
        do_read("R6 R10 los change code");
        do_read("R9 read keeps pending");
        chk("R9 irq after read", int_n, 0);
        set_mon(1, 1);
        do_read("R6 both changes code");
        do_write(mk(1, 0, 3'd3, 0, 1, 0));
        chk("R7 dpm still pending", int_n, 0);
        do_read("R7 clear los leaves dpm code");
        do_write(mk(1, 1, 3'd3, 0, 1, 0));
        chk("R7 all cleared irq", int_n, 1);
        set_mon(0, 0);
        chk("R7 masked after clear", int_n, 1);
        do_write(mk(0, 0, 3'd3, 0, 0, 1));
        chk("R8 reenable no irq", int_n, 1);
        set_mon(0, 1);
        chk("R8 dpm irq", int_n, 0);
        do_read("R10 dpm code over remote loop");
        do_write(mk(1, 1, 3'd3, 0, 0, 0));
    endtask

    task automatic t_abort();
        logic [7:0] rd;
        int oe_err;
        serial(8'h20, mk(1, 1, 3'd7, 1, 1, 1), 15, 1'b0, rd, oe_err);
        chk("R1 partial write ignored", {len_sel, tx_all_ones, local_loop, remote_loop},
            {m_len, m_taos, m_lloop, m_rloop});
        serial(8'h21, 8'h00, 11, 1'b1, rd, oe_err);
        chk("R3 abort drive window", oe_err, 0);
        chk("R3 abort releases sdo", sdo_oe, 0);
        do_read("R2 read after abort");
    endtask

    task automatic t_addr();
        logic [7:0] rd;
        int oe_err;
        serial(8'h22, mk(1, 1, 3'd6, 1, 0, 0), 16, 1'b0, rd, oe_err);
        chk("R11 wrong address write", {len_sel, tx_all_ones, local_loop, remote_loop},
            {m_len, m_taos, m_lloop, m_rloop});
        serial(8'h23, 8'h00, 16, 1'b0, rd, oe_err);
        chk("R11 wrong address read no drive", oe_err, 0);
    endtask

    initial begin
        wait_clk(8);
        rst = 1'b0;
        wait_clk(8);
        t_reset();
        t_controls();
        t_modes();
        t_live_masked();
        t_events();
        t_abort();
        t_addr();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule